// File: doc/BRIEF.md
# Serial Loader for a Loop-Current DAC Code

This block receives a DAC code over a three-wire serial link made of a bit line, a shift clock and a load strobe. Each rising edge of the shift clock pushes one bit into a 17-bit input register, most significant bit first. The block also counts the shift edges that arrive between load strobes. When the load strobe rises, the input register is copied into a parallel output latch. The accumulated edge count decides how that word is read.

A count of 0 to 16, taken modulo 32, marks a normal word. The latch then takes the 16 newest bits and a zero in the top position. A count of 17 to 31, taken modulo 32, marks an alarm word. The latch then takes the 17 newest bits. The bit shifted 17 edges before the strobe becomes the top bit. Any bits sent before that are dropped, so a host can write three whole bytes.

The three serial wires are asynchronous to the system clock. Each one passes through a two-flop synchronizer. Their edges are then found in the system clock domain. A one-cycle update strobe marks the cycle in which a new code and mode appear.

Top module: `dac_serial_loader`

## Requirements
- R1: Each rising edge of the serial clock shifts the synchronized data bit into the bottom of the input register. Earlier bits move one place toward the top, so the word arrives most significant bit first.
- R2: A rising edge of the load line loads the output latch. The update strobe is high for exactly one system cycle. That cycle is the third rising system-clock edge after the load line rises, and the new code and mode flag are valid in the same cycle.
- R3: If the number of serial clock edges since the previous load edge, taken modulo 32, is 0 to 16, the word is normal. The mode flag is 0. Code bits 15..0 hold the 16 most recently shifted bits, with the newest bit at bit 0, and code bit 16 is 0.
- R4: If that count modulo 32 is 17 to 31, the word is alarm data. The mode flag is 1. Code bits 16..0 hold the 17 most recently shifted bits, and the bit shifted 17 edges before the load becomes bit 16. Earlier bits are discarded.
- R5: The edge counter wraps modulo 32 and restarts from zero at every load edge. For example, 32 edges give a normal word, 33 and 48 edges give normal words, and 49 edges give an alarm word.
- R6: Between load edges, the code and mode outputs hold their values. Serial clock and data activity does not change them.
- R7: An active-low synchronous reset clears the code, the mode flag, the strobe, the input register and the edge counter.
- R8: The serial clock works correctly when each of its levels lasts at least two system clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ser_clk_i | input | 1 | Serial shift clock, asynchronous |
| ser_data_i | input | 1 | Serial data bit, asynchronous |
| ser_load_i | input | 1 | Load strobe, asynchronous; its rising edge loads the output latch |
| dac_code_o | output | 17 | Latched DAC code |
| alarm_mode_o | output | 1 | 1 when the latched code is alarm data |
| update_stb_o | output | 1 | One-cycle pulse when a new code is latched |

## Verification
The path from the load pin to the outputs has three registers: two synchronizer stages and the output latch. A load edge driven just after a falling system-clock edge therefore shows up at the outputs in the third system cycle. The bench drives each load rise on a falling edge and samples on the third falling edge that follows. It expects the strobe high in that sample and low one cycle later. Each serial bit is held for several system cycles before its clock edge, so the shift register has settled well before the load edge arrives. Every hold check samples only after all bits of a burst have gone in.

// File: rtl/dls_pkg.sv
package dls_pkg;
    typedef enum logic {
        MODE_NORMAL = 1'b0,
        MODE_ALARM  = 1'b1
    } dac_mode_e;
endpackage

// File: rtl/dls_sync.sv
module dls_sync #(
    parameter int N    = 1,
    parameter bit EDGE = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] async_i,
    output logic [N-1:0] sync_o
);
    typedef struct packed {
        logic [N-1:0] meta;
        logic [N-1:0] stab;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.meta = async_i;
        st_d.stab = st_q.meta;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    generate
        if (EDGE) begin : g_edge
            logic [N-1:0] prev_d, prev_q;
            assign prev_d = st_q.stab;
            always_ff @(posedge clk) begin
                if (!rst_n) prev_q <= '0;
                else        prev_q <= prev_d;
            end
            for (genvar i = 0; i < N; i++) begin : g_bit
                assign sync_o[i] = st_q.stab[i] & ~prev_q[i];
                // R2
                edge_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
                    sync_o[i] |=> !sync_o[i]);
            end
        end else begin : g_level
            assign sync_o = st_q.stab;
        end
    endgenerate
endmodule

// File: rtl/dls_shifter.sv
module dls_shifter #(
    parameter int SREG_BITS = 17,
    parameter int CNT_BITS  = 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 shift_i,
    input  logic                 bit_i,
    input  logic                 restart_i,
    output logic [SREG_BITS-1:0] sreg_o,
    output logic [CNT_BITS-1:0]  cnt_o
);
    localparam logic [CNT_BITS-1:0] ONE = CNT_BITS'(1);

    typedef struct packed {
        logic [SREG_BITS-1:0] sreg;
        logic [CNT_BITS-1:0]  cnt;
    } shf_t;

    shf_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (shift_i) begin
            st_d.sreg = {st_q.sreg[SREG_BITS-2:0], bit_i};
        end
        if (restart_i) begin
            st_d.cnt = shift_i ? ONE : '0;
        end else if (shift_i) begin
            st_d.cnt = st_q.cnt + ONE;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sreg_o = st_q.sreg;
    assign cnt_o  = st_q.cnt;

    // R1
    shift_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
        shift_i |=> (sreg_o[0] == $past(bit_i)));

    // R5
    cnt_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (restart_i && !shift_i) |=> (cnt_o == '0));
endmodule

// File: rtl/dls_latch.sv
module dls_latch
    import dls_pkg::*;
#(
    parameter int NORM_BITS = 16,
    parameter int CNT_BITS  = 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load_i,
    input  logic [NORM_BITS:0]   sreg_i,
    input  logic [CNT_BITS-1:0]  cnt_i,
    output logic [NORM_BITS:0]   code_o,
    output logic                 alarm_o,
    output logic                 stb_o
);
    localparam int CODE_BITS = NORM_BITS + 1;
    localparam logic [CNT_BITS-1:0] LIMIT = CNT_BITS'(NORM_BITS);

    typedef struct packed {
        logic [CODE_BITS-1:0] code;
        dac_mode_e            mode;
        logic                 stb;
    } lat_t;

    lat_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.stb = 1'b0;
        if (load_i) begin
            st_d.stb = 1'b1;
            if (cnt_i > LIMIT) begin
                st_d.mode = MODE_ALARM;
                st_d.code = sreg_i;
            end else begin
                st_d.mode = MODE_NORMAL;
                st_d.code = {1'b0, sreg_i[NORM_BITS-1:0]};
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{code: '0, mode: MODE_NORMAL, stb: 1'b0};
        else        st_q <= st_d;
    end

    assign code_o  = st_q.code;
    assign alarm_o = (st_q.mode == MODE_ALARM);
    assign stb_o   = st_q.stb;

    // R3
    normal_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stb_o && !alarm_o) |-> !code_o[NORM_BITS]);

    // R6
    code_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !stb_o |-> ($stable(code_o) && $stable(alarm_o)));

    // R7
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (code_o == '0 && !alarm_o && !stb_o));
endmodule

// File: rtl/dac_serial_loader.sv
module dac_serial_loader #(
    parameter int NORM_BITS = 16,
    parameter int CNT_BITS  = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ser_clk_i,
    input  logic               ser_data_i,
    input  logic               ser_load_i,
    output logic [NORM_BITS:0] dac_code_o,
    output logic               alarm_mode_o,
    output logic               update_stb_o
);
    localparam int SREG_BITS = NORM_BITS + 1;

    logic [1:0]           edges;
    logic                 data_s;
    logic [SREG_BITS-1:0] sreg;
    logic [CNT_BITS-1:0]  cnt;

    dls_sync #(.N(2), .EDGE(1'b1)) u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({ser_load_i, ser_clk_i}),
        .sync_o  (edges)
    );

    dls_sync #(.N(1), .EDGE(1'b0)) u_data (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (ser_data_i),
        .sync_o  (data_s)
    );

    dls_shifter #(.SREG_BITS(SREG_BITS), .CNT_BITS(CNT_BITS)) u_shf (
        .clk       (clk),
        .rst_n     (rst_n),
        .shift_i   (edges[0]),
        .bit_i     (data_s),
        .restart_i (edges[1]),
        .sreg_o    (sreg),
        .cnt_o     (cnt)
    );

    dls_latch #(.NORM_BITS(NORM_BITS), .CNT_BITS(CNT_BITS)) u_lat (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (edges[1]),
        .sreg_i  (sreg),
        .cnt_i   (cnt),
        .code_o  (dac_code_o),
        .alarm_o (alarm_mode_o),
        .stb_o   (update_stb_o)
    );
endmodule

// File: tb/sim_dac_serial_loader.sv
module sim_dac_serial_loader;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ser_clk = 1'b0;
    logic ser_data = 1'b0;
    logic ser_load = 1'b0;
    logic [16:0] code;
    logic alarm, stb;

    int n_chk = 0;
    int n_fail = 0;
    int half = 4;
    int cnt_m = 0;
    logic [127:0] hist = '0;

    always #4 clk = ~clk;

    dac_serial_loader u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .ser_clk_i    (ser_clk),
        .ser_data_i   (ser_data),
        .ser_load_i   (ser_load),
        .dac_code_o   (code),
        .alarm_mode_o (alarm),
        .update_stb_o (stb)
    );

    typedef struct packed {
        logic [6:0]  n;
        logic [63:0] v;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VECS [NV] = '{
        '{7'd16, 64'h0000_0000_0000_A5C3},
        '{7'd17, 64'h0000_0000_0001_3800},
        '{7'd24, 64'h0000_0000_00F3_3C00},
        '{7'd16, 64'h0000_0000_0000_FFFF},
        '{7'd0,  64'h0000_0000_0000_0000},
        '{7'd33, 64'h0000_0001_2345_6789},
        '{7'd48, 64'h0000_DEAD_BEEF_1357},
        '{7'd49, 64'h0001_5A5A_0F0F_2468},
        '{7'd31, 64'h0000_0000_4321_ABCD},
        '{7'd32, 64'h0000_0000_9876_0F1E},
        '{7'd15, 64'h0000_0000_0000_2A55}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic send(input int n, input logic [63:0] v);
        for (int i = n - 1; i >= 0; i--) begin
            @(negedge clk);
            ser_data = v[i];
            repeat (half) @(negedge clk);
            ser_clk = 1'b1;
            hist = {hist[126:0], v[i]};
            cnt_m++;
            repeat (half) @(negedge clk);
            ser_clk = 1'b0;
        end
        repeat (4) @(negedge clk);
    endtask

    // Raise load, check outputs on the third falling edge and the strobe drop after it
    task automatic load_and_check(input string tag);
        logic am;
        logic [16:0] ec;
        am = ((cnt_m % 32) > 16);
        ec = am ? hist[16:0] : {1'b0, hist[15:0]};
        @(negedge clk);
        ser_load = 1'b1;
        repeat (2) @(negedge clk);
        chk({tag, " R2 strobe early"}, 32'(stb), 32'd0);
        @(negedge clk);
        chk({tag, " R2 strobe"}, 32'(stb), 32'd1);
        chk({tag, am ? " R4 code" : " R3 code"}, 32'(code), 32'(ec));
        chk({tag, " R5 mode"}, 32'(alarm), 32'(am));
        @(negedge clk);
        chk({tag, " R2 strobe width"}, 32'(stb), 32'd0);
        ser_load = 1'b0;
        cnt_m = 0;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R7: reset state
        chk("R7 reset code", 32'(code), 32'd0);
        chk("R7 reset mode", 32'(alarm), 32'd0);
        chk("R7 reset strobe", 32'(stb), 32'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        for (int k = 0; k < NV; k++) begin
            send(int'(VECS[k].n), VECS[k].v);
            load_and_check($sformatf("vec%0d", k));
        end

        // R6: shifting without a load leaves the outputs alone
        begin
            logic [16:0] held;
            logic hm;
            held = code;
            hm = alarm;
            send(20, 64'h000A_BCDE);
            chk("R6 code held", 32'(code), 32'(held));
            chk("R6 mode held", 32'(alarm), 32'(hm));
            chk("R6 no strobe", 32'(stb), 32'd0);
            load_and_check("after hold");
        end

        // R8: fastest serial clock, two system cycles per level
        half = 2;
        send(17, 64'h0001_6C3A);
        load_and_check("fast R8 alarm");
        send(16, 64'h0000_93E1);
        load_and_check("fast R8 normal");
        half = 4;

        // R7: reset clears register and counter partway through a word
        send(10, 64'h0000_03FF);
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk("R7 mid reset code", 32'(code), 32'd0);
        chk("R7 mid reset mode", 32'(alarm), 32'd0);
        rst_n = 1'b1;
        hist = '0;
        cnt_m = 0;
        repeat (2) @(negedge clk);
        load_and_check("R7 after reset");

        // R1: most significant bit first, alarm word via three bytes
        send(24, 64'h0000_0000_0081_0001);
        load_and_check("R1 msb order");

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule